// File: doc/BRIEF.md
# Six-Control-Bit Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for a datapath of parameterised width (16 bits by default). It takes two operands, `x` and `y`, and six control bits, and produces a result word together with a zero flag and a negative flag. It has no opcode decoder. Every function comes from one fixed chain of steps:

- either operand may be cleared, and then bitwise inverted;
- the two conditioned operands are then summed or ANDed;
- the outcome may finally be inverted.

With the right settings, this chain gives constants, pass-through, negation, increment, decrement, sum, difference, AND and OR.

The unit is meant to sit between a register file and a write-back path. Upstream logic turns instructions into the six control bits, and that decoding is outside this block. The flags describe the final result, so a branch unit can consume them directly. Addition wraps around, and nothing reports carry or overflow.

Top module: `alu6_top`

## Requirements
- R1: Operand `x` is conditioned in a fixed order: clearing comes first, then inversion. With `clr_x_i`=1 and `inv_x_i`=1 the conditioned x is all ones. With only `clr_x_i` set it is zero, and with only `inv_x_i` set it is ~x.
- R2: Operand `y` is conditioned the same way, through `clr_y_i` then `inv_y_i`, independently of x. With both bits set the conditioned y is all ones.
- R3: When `add_sel_i`=1 the core result is the sum of the conditioned operands modulo 2^WIDTH. For example 0x7FFF+1 gives 0x8000 and 0xFFFF+1 gives 0x0000, and no overflow or carry is reported.
- R4: When `add_sel_i`=0 the core result is the bitwise AND of the conditioned operands.
- R5: When `inv_res_i`=1 the output `res_o` is the bitwise complement of the core result. Otherwise it equals the core result.
- R6: `zero_o` is 1 exactly when `res_o` is all zeros.
- R7: `neg_o` equals bit WIDTH-1 of `res_o`, that is, the result is negative in two's complement.
- R8: The controls are written in the order {clr_x, inv_x, clr_y, inv_y, add_sel, inv_res}. Setting 101010 gives the constant 0, 111111 gives 1, and 111010 gives all ones, whatever the operands.
- R9: Setting 011111 gives x+1 and setting 110111 gives y+1, modulo 2^WIDTH.
- R10: Setting 010011 gives x−y and setting 000111 gives y−x, modulo 2^WIDTH.
- R11: Both flags are taken from the output after the final inversion. For example, x=y=0 with setting 000001 gives `res_o`=all ones, `zero_o`=0 and `neg_o`=1.
- R12: All 18 standard settings give their named functions: 0, 1, −1, x, y, ~x, ~y, −x, −y, x+1, y+1, x−1, y−1, x+y, x−y, y−x, x&y and x|y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| clr_x_i | input | 1 | Clear x before inversion |
| inv_x_i | input | 1 | Invert the (possibly cleared) x |
| clr_y_i | input | 1 | Clear y before inversion |
| inv_y_i | input | 1 | Invert the (possibly cleared) y |
| add_sel_i | input | 1 | 1 selects sum, 0 selects AND |
| inv_res_i | input | 1 | Invert the core result |
| res_o | output | WIDTH | Final result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result sign bit |

## Verification
Every output is combinational, so the result and both flags are due in the same cycle that an operand or control bit changes. No register delay has to be counted. The bench applies each stimulus on a falling clock edge and samples on the following rising edge, half a period later, so the ripple chain has settled well before the check. The checker's properties evaluate on settled values of the same ports. The 18 standard settings are swept with pseudo-random operands, and all 64 control combinations are compared with a model built from the requirements.

// File: rtl/alu6_pkg.sv
package alu6_pkg;
   // Conditioning controls for one operand
   typedef struct packed {
      logic clr;
      logic inv;
   } opnd_ctl_t;

   localparam int unsigned MIN_WIDTH = 2;
endpackage

// File: rtl/alu6_opnd_cond.sv
module alu6_opnd_cond
   import alu6_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] opnd_i,
   input  opnd_ctl_t        ctl_i,
   output logic [WIDTH-1:0] opnd_o
);
   logic [WIDTH-1:0] cleared;

   // Clearing happens first, inversion acts on the cleared value
   always_comb begin
      cleared = ctl_i.clr ? '0 : opnd_i;
      opnd_o  = ctl_i.inv ? ~cleared : cleared;
   end
endmodule

// File: rtl/alu6_core.sv
module alu6_core #(
   parameter int unsigned WIDTH      = 16,
   parameter bit          USE_RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             add_sel_i,
   input  logic             inv_res_i,
   output logic [WIDTH-1:0] res_o
);
   logic [WIDTH-1:0] sum;
   logic [WIDTH-1:0] conj;
   logic [WIDTH-1:0] core;

   generate
      if (USE_RIPPLE) begin : g_ripple
         // Explicit carry chain; the carry out of the top bit is never formed
         logic [WIDTH-1:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i] = a_i[i] ^ b_i[i] ^ carry[i];
            if (i < WIDTH - 1) begin : g_cy
               assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
            end
         end
      end else begin : g_behav
         assign sum = a_i + b_i;
      end
   endgenerate

   assign conj = a_i & b_i;

   always_comb begin
      core  = add_sel_i ? sum : conj;
      res_o = inv_res_i ? ~core : core;
   end
endmodule

// File: rtl/alu6_flags.sv
module alu6_flags #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] res_i,
   output logic             zero_o,
   output logic             neg_o
);
   localparam int unsigned MSB = WIDTH - 1;

   assign zero_o = ~|res_i;
   assign neg_o  = res_i[MSB];
endmodule

// File: rtl/alu6_top.sv
module alu6_top
   import alu6_pkg::*;
#(
   parameter int unsigned WIDTH      = 16,
   parameter bit          USE_RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             clr_x_i,
   input  logic             inv_x_i,
   input  logic             clr_y_i,
   input  logic             inv_y_i,
   input  logic             add_sel_i,
   input  logic             inv_res_i,
   output logic [WIDTH-1:0] res_o,
   output logic             zero_o,
   output logic             neg_o
);
   generate
      if (WIDTH < MIN_WIDTH) begin : g_bad_width
         $error("alu6_top: WIDTH must be at least 2");
      end
   endgenerate

   opnd_ctl_t        ctl_x;
   opnd_ctl_t        ctl_y;
   logic [WIDTH-1:0] x_c;
   logic [WIDTH-1:0] y_c;

   assign ctl_x = '{clr: clr_x_i, inv: inv_x_i};
   assign ctl_y = '{clr: clr_y_i, inv: inv_y_i};

   alu6_opnd_cond #(.WIDTH(WIDTH)) i_cond_x (
      .opnd_i(x_i), .ctl_i(ctl_x), .opnd_o(x_c)
   );

   alu6_opnd_cond #(.WIDTH(WIDTH)) i_cond_y (
      .opnd_i(y_i), .ctl_i(ctl_y), .opnd_o(y_c)
   );

   alu6_core #(.WIDTH(WIDTH), .USE_RIPPLE(USE_RIPPLE)) i_core (
      .a_i(x_c), .b_i(y_c), .add_sel_i(add_sel_i), .inv_res_i(inv_res_i), .res_o(res_o)
   );

   alu6_flags #(.WIDTH(WIDTH)) i_flags (
      .res_i(res_o), .zero_o(zero_o), .neg_o(neg_o)
   );
endmodule

// File: rtl/alu6_checker.sv
module alu6_checker #(
   parameter int unsigned WIDTH = 16
) (
   input logic [WIDTH-1:0] x_i,
   input logic [WIDTH-1:0] y_i,
   input logic             clr_x_i,
   input logic             inv_x_i,
   input logic             clr_y_i,
   input logic             inv_y_i,
   input logic             add_sel_i,
   input logic             inv_res_i,
   input logic [WIDTH-1:0] res_o,
   input logic             zero_o,
   input logic             neg_o
);
   logic [5:0]       ctl;
   logic [WIDTH-1:0] one;

   assign ctl = {clr_x_i, inv_x_i, clr_y_i, inv_y_i, add_sel_i, inv_res_i};
   assign one = {{(WIDTH-1){1'b0}}, 1'b1};

   always_comb begin
      // R6: zero flag agrees with the final result
      p_zero_flag_r6: assert (zero_o == (res_o == '0));
      // R7: negative flag is the result sign bit
      p_neg_flag_r7: assert (neg_o == res_o[WIDTH-1]);
      // R11: flags come from the same word, so both can never be set
      p_flags_excl_r11: assert (!(zero_o && neg_o));
      // R8: constant zero setting
      if (ctl == 6'b101010) p_const_zero_r8: assert (res_o == '0);
      // R9: increment setting
      if (ctl == 6'b011111) p_incr_r9: assert (res_o == x_i + one);
      // R10: subtraction setting
      if (ctl == 6'b010011) p_sub_r10: assert (res_o == x_i - y_i);
      // R4: AND with nothing conditioned
      if (ctl == 6'b000000) p_and_r4: assert (res_o == (x_i & y_i));
   end
endmodule

bind alu6_top alu6_checker #(.WIDTH(WIDTH)) i_alu6_checker (
   .x_i(x_i), .y_i(y_i),
   .clr_x_i(clr_x_i), .inv_x_i(inv_x_i), .clr_y_i(clr_y_i), .inv_y_i(inv_y_i),
   .add_sel_i(add_sel_i), .inv_res_i(inv_res_i),
   .res_o(res_o), .zero_o(zero_o), .neg_o(neg_o)
);

// File: tb/test_alu6_top.sv
`timescale 1ns/1ps
module test_alu6_top;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic [W-1:0] x, y, res;
   logic [5:0]   ctl;
   logic         zr, ng;
   int           n_chk = 0;
   int           n_err = 0;
   logic [31:0]  seed = 32'h1234_5678;

   alu6_top #(.WIDTH(W)) i_alu6_top (
      .x_i(x), .y_i(y),
      .clr_x_i(ctl[5]), .inv_x_i(ctl[4]), .clr_y_i(ctl[3]), .inv_y_i(ctl[2]),
      .add_sel_i(ctl[1]), .inv_res_i(ctl[0]),
      .res_o(res), .zero_o(zr), .neg_o(ng)
   );

   function automatic logic [W-1:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed[W-1:0];
   endfunction

   // Model written from the requirements
   function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b, logic [5:0] c);
      logic [W-1:0] p, q, r;
      p = c[5] ? '0 : a;  p = c[4] ? ~p : p;
      q = c[3] ? '0 : b;  q = c[2] ? ~q : q;
      r = c[1] ? p + q : p & q;
      return c[0] ? ~r : r;
   endfunction

   task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [5:0] c);
      @(negedge clk);
      x = a; y = b; ctl = c;
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h (x=%h y=%h ctl=%b)", tag, act, exp, x, y, ctl);
      end
   endtask

   task automatic chk_all(string tag, logic [W-1:0] exp);
      chk(tag, res, exp);
      chk({tag, " R6 zero"}, {15'd0, zr}, {15'd0, exp == '0});
      chk({tag, " R7 neg"}, {15'd0, ng}, {15'd0, exp[W-1]});
   endtask

   task automatic t_idle();
      apply('0, '0, 6'b000000);
      chk_all("idle R4", 16'h0000);
   endtask

   task automatic t_order();
      apply(16'h1234, 16'h0000, 6'b111010);
      chk_all("R1 clear-then-invert x", 16'hFFFF);
      apply(16'h1234, 16'h0000, 6'b011010);
      chk_all("R1 invert-only x", 16'hEDCB);
      apply(16'h0000, 16'h5A5A, 6'b101110);
      chk_all("R2 clear-then-invert y", 16'hFFFF);
      apply(16'h0000, 16'h5A5A, 6'b100110);
      chk_all("R2 invert-only y", 16'hA5A5);
   endtask

   task automatic t_wrap();
      apply(16'h7FFF, 16'h0001, 6'b000010);
      chk_all("R3 wrap to negative", 16'h8000);
      apply(16'hFFFF, 16'h0001, 6'b000010);
      chk_all("R3 wrap to zero", 16'h0000);
      apply(16'hF0F0, 16'h3C3C, 6'b000000);
      chk_all("R4 and", 16'h3030);
      apply(16'hF0F0, 16'h3C3C, 6'b000001);
      chk_all("R5 nand", 16'hCFCF);
   endtask

   task automatic t_flags_after_inv();
      apply(16'h0000, 16'h0000, 6'b000001);
      chk_all("R11 flags after inversion", 16'hFFFF);
      apply(16'hFFFF, 16'hFFFF, 6'b000001);
      chk_all("R11 zero after inversion", 16'h0000);
   endtask

   task automatic t_special();
      for (int k = 0; k < 6; k++) begin
         logic [W-1:0] a, b;
         a = rnd(); b = rnd();
         if (k == 0) begin a = 16'hFFFF; b = 16'h0001; end
         apply(a, b, 6'b101010); chk_all("R8 zero", 16'h0000);
         apply(a, b, 6'b111111); chk_all("R8 one", 16'h0001);
         apply(a, b, 6'b111010); chk_all("R8 minus one", 16'hFFFF);
         apply(a, b, 6'b011111); chk_all("R9 x+1", a + 16'd1);
         apply(a, b, 6'b110111); chk_all("R9 y+1", b + 16'd1);
         apply(a, b, 6'b010011); chk_all("R10 x-y", a - b);
         apply(a, b, 6'b000111); chk_all("R10 y-x", b - a);
      end
   endtask

   task automatic t_canonical();
      logic [5:0] enc [18];
      enc = '{6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
              6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
              6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101};
      for (int r = 0; r < 8; r++) begin
         logic [W-1:0] a, b;
         a = rnd(); b = rnd();
         for (int i = 0; i < 18; i++) begin
            logic [W-1:0] e;
            case (i)
               0: e = 16'd0;     1: e = 16'd1;     2: e = 16'hFFFF;
               3: e = a;         4: e = b;         5: e = ~a;
               6: e = ~b;        7: e = -a;        8: e = -b;
               9: e = a + 1;     10: e = b + 1;    11: e = a - 1;
               12: e = b - 1;    13: e = a + b;    14: e = a - b;
               15: e = b - a;    16: e = a & b;    default: e = a | b;
            endcase
            apply(a, b, enc[i]);
            chk_all("R12 standard setting", e);
            chk("R12 model agrees", model(a, b, enc[i]), e);
         end
      end
   endtask

   task automatic t_all_ctl();
      for (int r = 0; r < 4; r++) begin
         logic [W-1:0] a, b;
         a = rnd(); b = rnd();
         for (int c = 0; c < 64; c++) begin
            apply(a, b, c[5:0]);
            chk_all("R1-model R2 R3 R4 R5 sweep", model(a, b, c[5:0]));
         end
      end
   endtask

   logic done = 1'b0;

   initial begin
      x = '0; y = '0; ctl = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle();
      t_order();
      t_wrap();
      t_flags_after_inv();
      t_special();
      t_canonical();
      t_all_ctl();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule